// File: doc/BRIEF.md
# Write-Invalidate Snooping Coherence Controller

This block sits beside one core in a small multi-core model whose cores share a single broadcast bus. It keeps a direct-mapped tag and state array for the core's cached lines, tracked at 64-byte granularity, and it keeps those lines coherent with the other cores through invalidation. When its core writes a line that it does not already own, the controller puts an invalidate for that line on the bus. It then stalls the core until each of the other cores has acknowledged the invalidate.

Every controller also listens to the bus. An invalidate from another core that names a line held here moves that line to Invalid. If the line was Modified, it is first written back to memory. An invalidate for a line not held here changes nothing. In both cases the source core gets an acknowledgement. A later read of a line that is no longer valid goes to memory.

Core requests always pass through a short in-order queue. Requests that the core issues during a stall wait there and are served in arrival order once the stalled write completes. Line states use the 2-bit encoding Invalid=0, Shared=1, Exclusive=2, Modified=3. Reads from memory install the line as Shared.

Top module: `snoop_inval_ctrl`

## Requirements
- R1: After reset every line is Invalid. `core_req_ready` is high. `core_stall`, `inv_out_valid`, `mem_req_valid`, `ack_out_valid` and `core_rsp_valid` are low.
- R2: A read of a line that is Invalid or whose tag misses raises `mem_req_valid` with `mem_req_write`=0 and the line address. The cycle after `mem_done` it responds with `core_rsp_hit`=0. A following read of that line responds with `core_rsp_hit`=1 and issues no memory request.
- R3: A write to a line not held Modified or Exclusive drives `inv_out_valid` for exactly one cycle, with the line address on `inv_out_line`. `core_stall` is high from that cycle onward.
- R4: The stalled write completes only once the union of the `ack_in_vec` bits received for every core other than this one (bit i = core i) covers all of them. The acks may come in any order, spread over cycles, or repeated. This core's own bit is ignored. In the cycle after the last needed ack, the write responds with `core_rsp_write`=1 and `core_stall` falls.
- R5: A write to a line held Modified responds with `core_rsp_hit`=1 and broadcasts nothing.
- R6: An invalidate from another core for a line not held here leaves the array unchanged and makes no memory request. This includes a line in the same set with a different tag. `ack_out_valid` is high for one cycle in the next cycle, with `ack_out_dst` equal to the source id.
- R7: An invalidate from another core that hits a Shared line makes that line Invalid and acknowledges in the next cycle without a memory write. The next read of the line goes to memory.
- R8: An invalidate that hits a Modified line first raises a memory write (`mem_req_write`=1) of that line. `ack_out_valid` stays low until the cycle after `mem_done`, and the line is Invalid afterwards.
- R9: An invalidate whose source id equals this core's id is ignored and produces no acknowledgement.
- R10: The queue holds QDEPTH requests, counting the one in progress. `core_req_ready` is low while it is full. Queued requests respond in arrival order.
- R11: The memory port has one owner at a time. A writeback requested while a read fill is outstanding waits until that fill's `mem_done`.
- R12: Address bits below the 64-byte line offset are ignored: byte addresses within one line hit the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core request present |
| core_req_write | input | 1 | 1 = write, 0 = read |
| core_req_addr | input | ADDR_W | Byte address |
| core_req_ready | output | 1 | Queue can take a request |
| core_rsp_valid | output | 1 | One-cycle completion pulse |
| core_rsp_write | output | 1 | Completed request was a write |
| core_rsp_line | output | ADDR_W-6 | Line address of completed request |
| core_rsp_hit | output | 1 | Served without memory or broadcast |
| core_stall | output | 1 | Core blocked on invalidate acknowledgements |
| inv_out_valid | output | 1 | Invalidate broadcast from this core |
| inv_out_line | output | ADDR_W-6 | Line being invalidated |
| snoop_in_valid | input | 1 | Invalidate seen on the bus |
| snoop_in_src | input | log2(NUM_CORES) | Id of the broadcasting core |
| snoop_in_line | input | ADDR_W-6 | Line named by the invalidate |
| ack_in_vec | input | NUM_CORES | Acknowledgements to this core, one bit per core |
| ack_out_valid | output | 1 | Acknowledgement from this core |
| ack_out_dst | output | log2(NUM_CORES) | Core being acknowledged |
| mem_req_valid | output | 1 | Memory request held until done |
| mem_req_write | output | 1 | 1 = writeback, 0 = fill read |
| mem_req_line | output | ADDR_W-6 | Line address for memory |
| mem_done | input | 1 | Memory completes the current request |

## Verification
The bench targets ack collection with partial, repeated and self-addressed ack bits. A controller that counted acks instead of masking them, or that included its own bit, would release the writer early or never. An invalidate naming a same-set line with a different tag checks that only a tag match invalidates; a set-only compare would drop a live line. A Modified hit must hold its ack behind the writeback, and a writeback that arrives during an outstanding fill must wait for it; getting either wrong shows up as an early ack or as two requests overlapping on the memory port. Requests queued during a stall are checked for order and for back-pressure at the depth limit, which catches reordering or overflow.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    MN_IDLE,
    MN_FILL,
    MN_BCAST,
    MN_COLLECT
  } main_st_e;

  typedef enum logic [1:0] {
    SN_IDLE,
    SN_WB,
    SN_ACK
  } snoop_st_e;

  function automatic logic owns_line(input line_st_e st);
    return (st == ST_M) || (st == ST_E);
  endfunction
endpackage

// File: rtl/coh_req_fifo.sv
`timescale 1ns/1ps
module coh_req_fifo #(
  parameter int W     = 27,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = slots[rd_p];

  always_ff @(posedge clk) begin
    if (push) slots[wr_p] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= bump(wr_p);
      if (pop)  rd_p <= bump(rd_p);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_fifo_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_no_pop_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> !full);
endmodule

// File: rtl/coh_tag_array.sv
`timescale 1ns/1ps
module coh_tag_array
  import coh_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] a_line,
  output line_st_e          a_st,
  output logic              a_hit,
  input  logic [LINE_W-1:0] b_line,
  output line_st_e          b_st,
  output logic              b_hit,
  input  logic              w_en,
  input  logic [LINE_W-1:0] w_line,
  input  line_st_e          w_st,
  input  logic              i_en,
  input  logic [LINE_W-1:0] i_line
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - SET_W;

  line_st_e         st_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS];

  function automatic logic [SET_W-1:0] set_of(input logic [LINE_W-1:0] l);
    return l[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] l);
    return l[LINE_W-1:SET_W];
  endfunction

  logic [SET_W-1:0] a_set, b_set, w_set, i_set;
  logic             i_match;

  assign a_set = set_of(a_line);
  assign b_set = set_of(b_line);
  assign w_set = set_of(w_line);
  assign i_set = set_of(i_line);

  assign a_st  = st_q[a_set];
  assign a_hit = (st_q[a_set] != ST_I) && (tag_q[a_set] == tag_of(a_line));
  assign b_st  = st_q[b_set];
  assign b_hit = (st_q[b_set] != ST_I) && (tag_q[b_set] == tag_of(b_line));

  // an install in the same set this cycle decides which tag the invalidate sees
  assign i_match = (w_en && (w_set == i_set)) ? (tag_of(w_line) == tag_of(i_line))
                                              : (tag_q[i_set] == tag_of(i_line));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SETS; k++) begin
        st_q[k]  <= ST_I;
        tag_q[k] <= '0;
      end
    end else begin
      if (w_en) begin
        st_q[w_set]  <= w_st;
        tag_q[w_set] <= tag_of(w_line);
      end
      if (i_en && i_match) st_q[i_set] <= ST_I;
    end
  end

  assert_snoop_clears_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_en && i_match) |=> (st_q[$past(i_set)] == ST_I));
endmodule

// File: rtl/coh_snoop_engine.sv
`timescale 1ns/1ps
module coh_snoop_engine
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_ID   = 0,
  parameter int LINE_W    = 26,
  parameter int ID_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [LINE_W-1:0] snp_line,
  output logic [LINE_W-1:0] look_line,
  input  line_st_e          look_st,
  input  logic              look_hit,
  output logic              inv_en,
  output logic [LINE_W-1:0] inv_line,
  input  logic              mem_free,
  output logic              wb_req,
  output logic [LINE_W-1:0] wb_line,
  input  logic              mem_done,
  output logic              ack_valid,
  output logic [ID_W-1:0]   ack_dst,
  output logic              busy
);
  snoop_st_e         st;
  logic [LINE_W-1:0] line_q;
  logic [ID_W-1:0]   src_q;
  logic              foreign, start, hit_dirty, wb_fin;

  assign foreign   = snp_valid && (snp_src != ID_W'(CORE_ID));
  assign start     = foreign && (st == SN_IDLE);
  assign look_line = (st == SN_IDLE) ? snp_line : line_q;
  assign hit_dirty = look_hit && (look_st == ST_M);
  assign wb_req    = (st == SN_WB) && mem_free;
  assign wb_line   = line_q;
  assign wb_fin    = wb_req && mem_done;
  assign inv_en    = (start && look_hit && !hit_dirty) || wb_fin;
  assign inv_line  = start ? snp_line : line_q;
  assign ack_valid = (st == SN_ACK);
  assign ack_dst   = src_q;
  assign busy      = (st != SN_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SN_IDLE;
      line_q <= '0;
      src_q  <= '0;
    end else begin
      case (st)
        SN_IDLE: if (start) begin
          line_q <= snp_line;
          src_q  <= snp_src;
          st     <= hit_dirty ? SN_WB : SN_ACK;
        end
        SN_WB:   if (wb_fin) st <= SN_ACK;
        default: st <= SN_IDLE;
      endcase
    end
  end

  assert_snoop_only_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    foreign |-> (st == SN_IDLE));
  assert_ack_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !ack_valid);
  assert_ack_after_writeback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fin |=> ack_valid);
  assert_no_self_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_dst != ID_W'(CORE_ID)));
endmodule

// File: rtl/snoop_inval_ctrl.sv
`timescale 1ns/1ps
module snoop_inval_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int CORE_ID    = 0,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 8,
  parameter int QDEPTH     = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W,
  localparam int ID_W      = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_req_valid,
  input  logic                 core_req_write,
  input  logic [ADDR_W-1:0]    core_req_addr,
  output logic                 core_req_ready,
  output logic                 core_rsp_valid,
  output logic                 core_rsp_write,
  output logic [LINE_W-1:0]    core_rsp_line,
  output logic                 core_rsp_hit,
  output logic                 core_stall,
  output logic                 inv_out_valid,
  output logic [LINE_W-1:0]    inv_out_line,
  input  logic                 snoop_in_valid,
  input  logic [ID_W-1:0]      snoop_in_src,
  input  logic [LINE_W-1:0]    snoop_in_line,
  input  logic [NUM_CORES-1:0] ack_in_vec,
  output logic                 ack_out_valid,
  output logic [ID_W-1:0]      ack_out_dst,
  output logic                 mem_req_valid,
  output logic                 mem_req_write,
  output logic [LINE_W-1:0]    mem_req_line,
  input  logic                 mem_done
);
  localparam int QW = LINE_W + 1;

  function automatic logic [NUM_CORES-1:0] others_mask();
    logic [NUM_CORES-1:0] m;
    for (int k = 0; k < NUM_CORES; k++) m[k] = (k != CORE_ID);
    return m;
  endfunction

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  localparam logic [NUM_CORES-1:0] OTHERS = others_mask();

  logic unused_offset_bits;
  assign unused_offset_bits = ^core_req_addr[OFF_W-1:0];

  // request queue
  logic          q_push, q_pop, q_empty, q_full;
  logic [QW-1:0] q_head;
  logic          head_wr;
  logic [LINE_W-1:0] head_line;

  assign q_push         = core_req_valid && !q_full;
  assign core_req_ready = !q_full;
  assign head_wr        = q_head[QW-1];
  assign head_line      = q_head[LINE_W-1:0];

  coh_req_fifo #(.W(QW), .DEPTH(QDEPTH)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   ({core_req_write, line_of(core_req_addr)}),
    .pop   (q_pop),
    .dout  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  // tag/state array: port a for the core, port b for snoops
  line_st_e          a_st, b_st, w_st;
  logic              a_hit, b_hit, w_en, i_en;
  logic [LINE_W-1:0] b_line, i_line;

  // snoop side
  logic              sn_busy, wb_req, mem_free;
  logic [LINE_W-1:0] wb_line;

  // main controller
  main_st_e             mst, mst_d;
  logic [NUM_CORES-1:0] acc, acc_d, acks_now;
  logic                 acks_done, rsp_set, rsp_hit_d, snoop_start, fill_ok;

  assign snoop_start = snoop_in_valid && (snoop_in_src != ID_W'(CORE_ID));
  assign fill_ok     = !sn_busy && !snoop_start;
  assign mem_free    = (mst != MN_FILL);
  assign acks_now    = acc | (ack_in_vec & OTHERS);
  assign acks_done   = (acks_now == OTHERS);

  coh_tag_array #(.LINE_W(LINE_W), .SETS(SETS)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_line (head_line),
    .a_st   (a_st),
    .a_hit  (a_hit),
    .b_line (b_line),
    .b_st   (b_st),
    .b_hit  (b_hit),
    .w_en   (w_en),
    .w_line (head_line),
    .w_st   (w_st),
    .i_en   (i_en),
    .i_line (i_line)
  );

  coh_snoop_engine #(
    .NUM_CORES (NUM_CORES),
    .CORE_ID   (CORE_ID),
    .LINE_W    (LINE_W),
    .ID_W      (ID_W)
  ) u_snoop (
    .clk       (clk),
    .rst_n     (rst_n),
    .snp_valid (snoop_in_valid),
    .snp_src   (snoop_in_src),
    .snp_line  (snoop_in_line),
    .look_line (b_line),
    .look_st   (b_st),
    .look_hit  (b_hit),
    .inv_en    (i_en),
    .inv_line  (i_line),
    .mem_free  (mem_free),
    .wb_req    (wb_req),
    .wb_line   (wb_line),
    .mem_done  (mem_done),
    .ack_valid (ack_out_valid),
    .ack_dst   (ack_out_dst),
    .busy      (sn_busy)
  );

  always_comb begin
    mst_d     = mst;
    acc_d     = acc;
    q_pop     = 1'b0;
    w_en      = 1'b0;
    w_st      = ST_I;
    rsp_set   = 1'b0;
    rsp_hit_d = 1'b0;
    case (mst)
      MN_IDLE: if (!q_empty) begin
        if (!head_wr && a_hit) begin
          q_pop = 1'b1; rsp_set = 1'b1; rsp_hit_d = 1'b1;
        end else if (!head_wr) begin
          if (fill_ok) mst_d = MN_FILL;
        end else if (a_hit && owns_line(a_st)) begin
          w_en = 1'b1; w_st = ST_M;
          q_pop = 1'b1; rsp_set = 1'b1; rsp_hit_d = 1'b1;
        end else begin
          mst_d = MN_BCAST;
        end
      end
      MN_FILL: if (mem_done) begin
        w_en = 1'b1; w_st = ST_S;
        q_pop = 1'b1; rsp_set = 1'b1;
        mst_d = MN_IDLE;
      end
      MN_BCAST: begin
        acc_d = '0;
        mst_d = MN_COLLECT;
      end
      default: begin
        acc_d = acks_now;
        if (acks_done) begin
          w_en = 1'b1; w_st = ST_M;
          q_pop = 1'b1; rsp_set = 1'b1;
          mst_d = MN_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst            <= MN_IDLE;
      acc            <= '0;
      core_rsp_valid <= 1'b0;
      core_rsp_write <= 1'b0;
      core_rsp_line  <= '0;
      core_rsp_hit   <= 1'b0;
    end else begin
      mst            <= mst_d;
      acc            <= acc_d;
      core_rsp_valid <= rsp_set;
      if (rsp_set) begin
        core_rsp_write <= head_wr;
        core_rsp_line  <= head_line;
        core_rsp_hit   <= rsp_hit_d;
      end
    end
  end

  assign core_stall    = (mst == MN_BCAST) || (mst == MN_COLLECT);
  assign inv_out_valid = (mst == MN_BCAST);
  assign inv_out_line  = head_line;
  assign mem_req_valid = (mst == MN_FILL) || wb_req;
  assign mem_req_write = wb_req;
  assign mem_req_line  = wb_req ? wb_line : head_line;

  assert_inv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_out_valid |=> (!inv_out_valid && core_stall));
  assert_stall_until_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mst == MN_COLLECT && !acks_done) |=> core_stall);
  assert_write_done_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mst == MN_COLLECT && acks_done) |=> (core_rsp_valid && core_rsp_write && !core_stall));
  assert_fill_is_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mst == MN_FILL) |-> (mem_req_valid && !mem_req_write));
  assert_mem_single_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !((mst == MN_FILL) && wb_req));
endmodule

// File: tb/snoop_inval_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_inval_ctrl_tb;
  localparam int LW = 26;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_req_valid = 1'b0, core_req_write = 1'b0;
  logic [31:0]   core_req_addr = '0;
  logic          core_req_ready, core_rsp_valid, core_rsp_write, core_rsp_hit, core_stall;
  logic [LW-1:0] core_rsp_line, inv_out_line, mem_req_line;
  logic          inv_out_valid, ack_out_valid, mem_req_valid, mem_req_write;
  logic          snoop_in_valid = 1'b0;
  logic [IW-1:0] snoop_in_src = '0, ack_out_dst;
  logic [LW-1:0] snoop_in_line = '0;
  logic [3:0]    ack_in_vec = '0;
  logic          mem_done = 1'b0;

  int n_checks = 0, n_err = 0;
  int mem_cyc = 0, inv_cyc = 0, ack_cyc = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  snoop_inval_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(core_req_valid), .core_req_write(core_req_write),
    .core_req_addr(core_req_addr), .core_req_ready(core_req_ready),
    .core_rsp_valid(core_rsp_valid), .core_rsp_write(core_rsp_write),
    .core_rsp_line(core_rsp_line), .core_rsp_hit(core_rsp_hit),
    .core_stall(core_stall), .inv_out_valid(inv_out_valid), .inv_out_line(inv_out_line),
    .snoop_in_valid(snoop_in_valid), .snoop_in_src(snoop_in_src),
    .snoop_in_line(snoop_in_line), .ack_in_vec(ack_in_vec),
    .ack_out_valid(ack_out_valid), .ack_out_dst(ack_out_dst),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_line(mem_req_line), .mem_done(mem_done)
  );

  always @(posedge clk) begin
    if (mem_req_valid) mem_cyc++;
    if (inv_out_valid) inv_cyc++;
    if (ack_out_valid) ack_cyc++;
  end

  function automatic logic [LW-1:0] ln(input logic [31:0] a);
    return a[31:6];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    end
  endtask

  task automatic send_req(input logic wr, input logic [31:0] a);
    core_req_valid = 1'b1; core_req_write = wr; core_req_addr = a;
    @(negedge clk);
    core_req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input string req, output logic hit, output logic wr,
                          output logic [LW-1:0] line);
    bit got = 0;
    hit = 0; wr = 0; line = '0;
    for (int i = 0; i < 60; i++) begin
      if (core_rsp_valid) begin
        got = 1; hit = core_rsp_hit; wr = core_rsp_write; line = core_rsp_line;
        break;
      end
      @(negedge clk);
    end
    chk({req, " response arrives"}, got, 1);
    if (got) @(negedge clk);
  endtask

  task automatic wait_mem(input string req);
    bit got = 0;
    for (int i = 0; i < 60; i++) begin
      if (mem_req_valid) begin got = 1; break; end
      @(negedge clk);
    end
    chk({req, " memory request appears"}, got, 1);
  endtask

  task automatic mem_pulse();
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
  endtask

  task automatic ack_pulse(input logic [3:0] v);
    ack_in_vec = v;
    @(negedge clk);
    ack_in_vec = '0;
  endtask

  task automatic snoop_pulse(input logic [IW-1:0] src, input logic [LW-1:0] l);
    snoop_in_valid = 1'b1; snoop_in_src = src; snoop_in_line = l;
    @(negedge clk);
    snoop_in_valid = 1'b0;
  endtask

  localparam logic [31:0] A  = 32'h0000_1000;
  localparam logic [31:0] B  = 32'h0000_2040;
  localparam logic [31:0] BX = 32'h0000_2240;
  localparam logic [31:0] C  = 32'h0000_3080;
  localparam logic [31:0] D  = 32'h0000_40C0;
  localparam logic [31:0] F  = 32'h0000_5100;

  task automatic read_fill(input string req, input logic [31:0] a);
    logic h, w; logic [LW-1:0] l;
    send_req(1'b0, a);
    wait_mem(req);
    chk({req, " fill is a read"}, mem_req_write, 0);
    chk({req, " fill line"}, mem_req_line, ln(a));
    mem_pulse();
    wait_rsp(req, h, w, l);
    chk({req, " fill rsp hit"}, h, 0);
    chk({req, " fill rsp line"}, l, ln(a));
  endtask

  task automatic t_reset();
    chk("R1 ready", core_req_ready, 1);
    chk("R1 stall", core_stall, 0);
    chk("R1 inv", inv_out_valid, 0);
    chk("R1 mem", mem_req_valid, 0);
    chk("R1 ack", ack_out_valid, 0);
    chk("R1 rsp", core_rsp_valid, 0);
  endtask

  task automatic t_read_miss_then_hit();
    logic h, w; logic [LW-1:0] l; int m0;
    read_fill("R2 R1", A);
    m0 = mem_cyc;
    send_req(1'b0, A + 32'd8);
    wait_rsp("R2 R12", h, w, l);
    chk("R2 second read hit", h, 1);
    chk("R12 same line offset", l, ln(A));
    chk("R2 no memory on hit", mem_cyc, m0);
  endtask

  task automatic t_write_shared();
    logic h, w; logic [LW-1:0] l; bit seen = 0; int i0;
    i0 = inv_cyc;
    send_req(1'b1, A + 32'd16);
    for (int i = 0; i < 20; i++) begin
      if (inv_out_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R3 invalidate broadcast", seen, 1);
    chk("R3 invalidate line", inv_out_line, ln(A));
    chk("R3 stall with broadcast", core_stall, 1);
    @(negedge clk);
    chk("R3 broadcast one cycle", inv_out_valid, 0);
    ack_pulse(4'b0101);
    @(negedge clk);
    chk("R4 stall after partial acks", core_stall, 1);
    chk("R4 no rsp after partial acks", core_rsp_valid, 0);
    ack_pulse(4'b0100);
    ack_pulse(4'b0010);
    chk("R4 stall with core3 missing", core_stall, 1);
    chk("R4 no rsp with core3 missing", core_rsp_valid, 0);
    ack_pulse(4'b1000);
    chk("R4 rsp after last ack", core_rsp_valid, 1);
    chk("R4 stall released", core_stall, 0);
    chk("R4 rsp is write", core_rsp_write, 1);
    wait_rsp("R4", h, w, l);
    chk("R3 single broadcast cycle", inv_cyc - i0, 1);
  endtask

  task automatic t_write_modified();
    logic h, w; logic [LW-1:0] l; int i0;
    i0 = inv_cyc;
    send_req(1'b1, A + 32'd40);
    wait_rsp("R5", h, w, l);
    chk("R5 hit on modified", h, 1);
    chk("R5 write flag", w, 1);
    chk("R12 line of offset 40", l, ln(A));
    chk("R5 no broadcast", inv_cyc, i0);
  endtask

  task automatic t_snoop_not_held();
    logic h, w; logic [LW-1:0] l; int m0;
    read_fill("R6 setup", B);
    m0 = mem_cyc;
    snoop_pulse(2'd2, ln(BX));
    chk("R6 ack next cycle", ack_out_valid, 1);
    chk("R6 ack destination", ack_out_dst, 2);
    @(negedge clk);
    chk("R6 ack one cycle", ack_out_valid, 0);
    send_req(1'b0, B);
    wait_rsp("R6", h, w, l);
    chk("R6 same-set line still held", h, 1);
    chk("R6 no memory traffic", mem_cyc, m0);
  endtask

  task automatic t_snoop_own();
    logic h, w; logic [LW-1:0] l; int a0;
    a0 = ack_cyc;
    snoop_pulse(2'd0, ln(B));
    repeat (3) @(negedge clk);
    chk("R9 no self ack", ack_cyc, a0);
    send_req(1'b0, B);
    wait_rsp("R9", h, w, l);
    chk("R9 line kept", h, 1);
  endtask

  task automatic t_snoop_shared();
    int m0;
    read_fill("R7 setup", C);
    m0 = mem_cyc;
    snoop_pulse(2'd1, ln(C));
    chk("R7 ack next cycle", ack_out_valid, 1);
    chk("R7 ack destination", ack_out_dst, 1);
    chk("R7 no writeback", mem_cyc, m0);
    @(negedge clk);
    read_fill("R7 refetch", C);
  endtask

  task automatic t_snoop_modified();
    snoop_pulse(2'd3, ln(A));
    chk("R8 no early ack", ack_out_valid, 0);
    chk("R8 writeback requested", mem_req_valid, 1);
    chk("R8 writeback is write", mem_req_write, 1);
    chk("R8 writeback line", mem_req_line, ln(A));
    repeat (2) @(negedge clk);
    chk("R8 ack held during writeback", ack_out_valid, 0);
    mem_pulse();
    chk("R8 ack after writeback", ack_out_valid, 1);
    chk("R8 ack destination", ack_out_dst, 3);
    @(negedge clk);
    read_fill("R8 refetch", A);
  endtask

  task automatic t_queue_order();
    logic h[4], w[4]; logic [LW-1:0] l[4]; bit seen = 0;
    send_req(1'b1, D);
    for (int i = 0; i < 20; i++) begin
      if (inv_out_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R10 broadcast for queued write", seen, 1);
    @(negedge clk);
    send_req(1'b1, D + 32'd4);
    send_req(1'b0, D + 32'd8);
    chk("R10 ready with room", core_req_ready, 1);
    send_req(1'b1, D + 32'd12);
    chk("R10 ready low when full", core_req_ready, 0);
    chk("R10 still stalled", core_stall, 1);
    ack_pulse(4'b1110);
    for (int k = 0; k < 4; k++) wait_rsp("R10", h[k], w[k], l[k]);
    chk("R10 order write flags", {w[0], w[1], w[2], w[3]}, 4'b1101);
    chk("R10 order hit flags", {h[0], h[1], h[2], h[3]}, 4'b0111);
    chk("R10 line", l[3], ln(D));
    chk("R10 ready after drain", core_req_ready, 1);
  endtask

  task automatic t_mem_arbitration();
    logic h, w; logic [LW-1:0] l; bit seen = 0;
    send_req(1'b0, F);
    wait_mem("R11");
    snoop_pulse(2'd1, ln(D));
    for (int i = 0; i < 3; i++) begin
      chk("R11 fill keeps port", mem_req_write, 0);
      chk("R11 fill line held", mem_req_line, ln(F));
      @(negedge clk);
    end
    chk("R11 no ack before writeback", ack_out_valid, 0);
    mem_pulse();
    wait_rsp("R11", h, w, l);
    chk("R11 fill rsp line", l, ln(F));
    for (int i = 0; i < 10; i++) begin
      if (mem_req_valid && mem_req_write) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R11 writeback after fill", seen, 1);
    chk("R11 writeback line", mem_req_line, ln(D));
    mem_pulse();
    chk("R11 ack after writeback", ack_out_valid, 1);
    chk("R11 ack destination", ack_out_dst, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss_then_hit();
    t_write_shared();
    t_write_modified();
    t_snoop_not_held();
    t_snoop_own();
    t_snoop_shared();
    t_snoop_modified();
    t_queue_order();
    t_mem_arbitration();
    repeat (2) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!reported) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      report();
      $finish;
    end
  end
endmodule